// File: doc/BRIEF.md
# Asynchronous SRAM-Bus Slave to Dual-Port RAM Bridge

This block lets a microcontroller reach an on-chip dual-port RAM through its asynchronous SRAM-style external memory bus. The bus side (active-low chip select, output enable and write enable, an address bus and a bidirectional data bus) is oversampled by a fabric clock. That clock is a plain input that runs at four times the bus reference clock. The bus reference clock itself is never used. One RAM port serves the bus. The other port is open to internal logic.

Every bus control line goes through a two-flop synchronizer. A third registered stage keeps the previous value for edge detection. The controller may pull chip select and output enable low before the address has settled. For that reason the bridge never trusts the address when an access begins. A write is committed only when synchronized chip select returns high. It uses the address and data held from the last sampling cycle in which chip select was still low. During a read, the RAM is addressed from the synchronized address on every cycle. The registered read data therefore follows an address that settles late, and the data pins are driven only while a read is active.

Top module: `xbus_ram_bridge`

## Requirements
- R1: While reset is high and in the cycle after it, the data pins are not driven (`bus_drive` low) and no RAM write takes place.
- R2: A bus write (chip select and write enable low) stores the address and data present on the pins in the final sampled cycle before chip select rises. Values present only earlier in the access, including while the address is unsettled, are not stored.
- R3: Each write access produces exactly one RAM write, lasting one clock cycle, after chip select returns high.
- R4: A chip-select-low access during which write enable stays high writes nothing, even if the data pins carry a value.
- R5: The bridge drives the data pins (`bus_drive` high) only while chip select and output enable are both low and write enable is high. In every other case the pins are high-impedance.
- R6: During a read, the data pins carry the RAM word at the current address. If the address changes while the read is active, the output follows the new address.
- R7: Toggling write enable or output enable while chip select stays high neither writes the RAM nor drives the data pins.
- R8: The internal port reads (one cycle of latency) and writes the same storage as the bus port, so each side sees words written by the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, four times the bus reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs_n | input | 1 | Bus chip select, active low |
| bus_oe_n | input | 1 | Bus output enable (read strobe), active low |
| bus_we_n | input | 1 | Bus write enable, active low |
| bus_addr | input | ADDR_W | Bus word address |
| bus_data | inout | DATA_W | Bidirectional bus data |
| bus_drive | output | 1 | High while the bridge drives `bus_data` |
| int_we | input | 1 | Internal port write strobe |
| int_addr | input | ADDR_W | Internal port address |
| int_wdata | input | DATA_W | Internal port write data |
| int_rdata | output | DATA_W | Internal port read data, registered |

## Verification
The embedded assertions check the per-cycle rules on every clock. A write pulse never lasts longer than one cycle and occurs only just after chip select rises. The held write address and data stay unchanged while that pulse is active. The data pins are released during reset and whenever synchronized chip select is high. Only the bench scenarios can show that the right word reaches the right address. They cover an address that settles late in a write, a read that follows a late address change, accesses that must leave memory untouched, and words passed between the bus port and the internal port.

// File: rtl/xbb_pkg.sv
package xbb_pkg;

  // Active-low bus strobes, as one sampled group
  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
  } xbb_ctl_t;

  localparam xbb_ctl_t XBB_CTL_IDLE = '{cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1};

endpackage

// File: rtl/xbb_sync.sv
module xbb_sync #(
  parameter int          WIDTH   = 1,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/xbb_dpram.sv
module xbb_dpram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_waddr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic [ADDR_W-1:0] a_raddr,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Port A: the bus side. Writes come from the commit path; reads follow
  // the live synchronized address.
  always_ff @(posedge clk) begin
    if (a_we) mem[a_waddr] <= a_wdata;
    a_rdata <= mem[a_raddr];
  end

  // Port B: the internal side.
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wdata;
    b_rdata <= mem[b_addr];
  end

endmodule

// File: rtl/xbb_ctrl.sv
module xbb_ctrl
  import xbb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  xbb_ctl_t          ctl_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [DATA_W-1:0] data_s,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              drive_en
);

  logic cs_prev;
  logic we_seen;
  logic cs_rise;

  // Third stage: previous synchronized chip select
  always_ff @(posedge clk) begin
    if (rst) cs_prev <= 1'b1;
    else     cs_prev <= ctl_s.cs_n;
  end

  assign cs_rise = ctl_s.cs_n & ~cs_prev;

  // Hold the address and data of the latest cycle with chip select low
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_addr <= '0;
      wr_data <= '0;
    end else if (!ctl_s.cs_n) begin
      wr_addr <= addr_s;
      wr_data <= data_s;
    end
  end

  // Remember whether write enable was seen low during this access
  always_ff @(posedge clk) begin
    if (rst)                        we_seen <= 1'b0;
    else if (cs_rise)               we_seen <= 1'b0;
    else if (!ctl_s.cs_n && !ctl_s.we_n) we_seen <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) wr_en <= 1'b0;
    else     wr_en <= cs_rise & we_seen;
  end

  always_ff @(posedge clk) begin
    if (rst) drive_en <= 1'b0;
    else     drive_en <= ~ctl_s.cs_n & ~ctl_s.oe_n & ctl_s.we_n;
  end

  // R3: a write pulse never lasts two cycles
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R3: a write pulse only follows a chip-select release
  a_r3_after_release: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ctl_s.cs_n);

  // R2: the committed address and data do not move while committing
  a_r2_hold_stable: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($stable(wr_addr) && $stable(wr_data)));

  // R5/R7: no drive in the cycle after chip select was seen high
  a_r7_idle_no_drive: assert property (@(posedge clk) disable iff (rst)
    ctl_s.cs_n |=> !drive_en);

  // R5: never drive the pins in the cycle write enable was seen low
  a_r5_no_drive_on_write: assert property (@(posedge clk) disable iff (rst)
    !ctl_s.we_n |=> !drive_en);

  // R1: reset leaves outputs quiet in the next cycle
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!drive_en && !wr_en));

endmodule

// File: rtl/xbus_ram_bridge.sv
module xbus_ram_bridge
  import xbb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs_n,
  input  logic              bus_oe_n,
  input  logic              bus_we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  inout  wire  [DATA_W-1:0] bus_data,
  output logic              bus_drive,
  input  logic              int_we,
  input  logic [ADDR_W-1:0] int_addr,
  input  logic [DATA_W-1:0] int_wdata,
  output logic [DATA_W-1:0] int_rdata
);

  localparam int CTL_W = $bits(xbb_ctl_t);

  xbb_ctl_t          ctl_raw;
  xbb_ctl_t          ctl_s;
  logic [CTL_W-1:0]  ctl_s_vec;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] data_s;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              drive_en;
  logic [DATA_W-1:0] rd_word;

  assign ctl_raw = '{cs_n: bus_cs_n, oe_n: bus_oe_n, we_n: bus_we_n};

  xbb_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(XBB_CTL_IDLE)) u_sync_ctl (
    .clk (clk), .rst (rst), .din (ctl_raw), .dout (ctl_s_vec)
  );
  assign ctl_s = xbb_ctl_t'(ctl_s_vec);

  xbb_sync #(.WIDTH(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_addr (
    .clk (clk), .rst (rst), .din (bus_addr), .dout (addr_s)
  );

  xbb_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
    .clk (clk), .rst (rst), .din (bus_data), .dout (data_s)
  );

  xbb_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ctl_s    (ctl_s),
    .addr_s   (addr_s),
    .data_s   (data_s),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .drive_en (drive_en)
  );

  xbb_dpram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk     (clk),
    .a_we    (wr_en),
    .a_waddr (wr_addr),
    .a_wdata (wr_data),
    .a_raddr (addr_s),
    .a_rdata (rd_word),
    .b_we    (int_we),
    .b_addr  (int_addr),
    .b_wdata (int_wdata),
    .b_rdata (int_rdata)
  );

  assign bus_drive = drive_en;
  assign bus_data  = drive_en ? rd_word : {DATA_W{1'bz}};

  // R1: pins released while reset is applied
  a_r1_released_in_reset: assert property (@(posedge clk)
    rst |=> !bus_drive);

endmodule

// File: tb/sim_xbus_ram_bridge.sv
module sim_xbus_ram_bridge;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NV = 6;

  // {address, data}
  localparam logic [AW+DW-1:0] VEC [NV] = '{
    {8'h00, 16'h1234}, {8'h01, 16'hABCD}, {8'h7F, 16'h0000},
    {8'h80, 16'hFFFF}, {8'hFE, 16'h5A5A}, {8'hFF, 16'hA5A5}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] tb_dout = '0;
  logic          tb_drv = 1'b0;
  wire  [DW-1:0] bus_data;
  logic          bus_drive;
  logic          int_we = 1'b0;
  logic [AW-1:0] int_addr = '0;
  logic [DW-1:0] int_wdata = '0;
  logic [DW-1:0] int_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign bus_data = tb_drv ? tb_dout : {DW{1'bz}};

  xbus_ram_bridge #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk (clk), .rst (rst),
    .bus_cs_n (cs_n), .bus_oe_n (oe_n), .bus_we_n (we_n),
    .bus_addr (addr), .bus_data (bus_data), .bus_drive (bus_drive),
    .int_we (int_we), .int_addr (int_addr),
    .int_wdata (int_wdata), .int_rdata (int_rdata)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addr = a; tb_dout = d; tb_drv = 1'b1;
    #3 cs_n = 1'b0; we_n = 1'b0;
    clocks(6);
    we_n = 1'b1; cs_n = 1'b1;
    clocks(6);
    tb_drv = 1'b0;
  endtask

  task automatic int_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); int_addr = a;
    @(negedge clk); d = int_rdata;
  endtask

  task automatic int_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk); int_addr = a; int_wdata = d; int_we = 1'b1;
    @(negedge clk); int_we = 1'b0;
  endtask

  task automatic bus_read_start(input logic [AW-1:0] a);
    addr = a;
    #3 cs_n = 1'b0; oe_n = 1'b0;
  endtask

  task automatic bus_read_end();
    oe_n = 1'b1; cs_n = 1'b1;
    clocks(6);
  endtask

  initial begin
    logic [DW-1:0] rd;
    clocks(3);
    // R1: reset state
    check("R1 drive in reset", {15'd0, bus_drive}, 16'd0);
    // Bus strobes active during reset must not write or drive
    addr = 8'h10; tb_dout = 16'hDEAD; tb_drv = 1'b1; cs_n = 1'b0; we_n = 1'b0;
    clocks(3);
    cs_n = 1'b1; we_n = 1'b1;
    clocks(2);
    tb_drv = 1'b0;
    rst = 1'b0;
    clocks(1);
    check("R1 drive after reset", {15'd0, bus_drive}, 16'd0);
    int_write(8'h10, 16'h0101);
    clocks(6);
    int_read(8'h10, rd);
    check("R1 no write after reset", rd, 16'h0101);

    // Table walk: write each vector by bus, read by internal and by bus
    for (int i = 0; i < NV; i++) bus_write(VEC[i][AW+DW-1:DW], VEC[i][DW-1:0]);
    for (int i = 0; i < NV; i++) begin
      int_read(VEC[i][AW+DW-1:DW], rd);
      check("R8 internal sees bus write", rd, VEC[i][DW-1:0]);
      bus_read_start(VEC[i][AW+DW-1:DW]);
      clocks(6);
      check("R5 drive during read", {15'd0, bus_drive}, 16'd1);
      check("R6 read data", bus_data, VEC[i][DW-1:0]);
      bus_read_end();
      check("R5 released after read", {15'd0, bus_drive}, 16'd0);
    end

    // R8: internal write seen on bus
    int_write(8'h33, 16'hC0DE);
    bus_read_start(8'h33);
    clocks(6);
    check("R8 bus sees internal write", bus_data, 16'hC0DE);
    // R6: late address change during active read
    addr = 8'h01;
    clocks(5);
    check("R6 follows late address", bus_data, 16'hABCD);
    bus_read_end();

    // R2: address unsettled at start of write, correct value at the end
    int_write(8'h44, 16'h4444);
    int_write(8'h45, 16'h4545);
    addr = 8'h44; tb_dout = 16'hBAD0; tb_drv = 1'b1;
    #3 cs_n = 1'b0; we_n = 1'b0;
    clocks(3);
    check("R5 no drive during write", {15'd0, bus_drive}, 16'd0);
    addr = 8'h45; tb_dout = 16'h9876;
    clocks(4);
    we_n = 1'b1; cs_n = 1'b1;
    clocks(6);
    tb_drv = 1'b0;
    int_read(8'h45, rd);
    check("R2 final address written", rd, 16'h9876);
    int_read(8'h44, rd);
    check("R2 early address untouched", rd, 16'h4444);

    // R4: chip select low, write enable high, pins carrying a value
    int_write(8'h50, 16'h5050);
    addr = 8'h50; tb_dout = 16'h1111; tb_drv = 1'b1;
    #3 cs_n = 1'b0;
    clocks(6);
    check("R5 no drive with oe high", {15'd0, bus_drive}, 16'd0);
    cs_n = 1'b1;
    clocks(6);
    tb_drv = 1'b0;
    int_read(8'h50, rd);
    check("R4 no write without we", rd, 16'h5050);

    // R7: strobes toggled with chip select high
    addr = 8'h50; tb_dout = 16'h2222; tb_drv = 1'b1;
    #3 we_n = 1'b0; oe_n = 1'b0;
    clocks(5);
    check("R7 no drive without cs", {15'd0, bus_drive}, 16'd0);
    we_n = 1'b1;
    clocks(5);
    check("R7 no drive oe only", {15'd0, bus_drive}, 16'd0);
    oe_n = 1'b1;
    clocks(4);
    tb_drv = 1'b0;
    int_read(8'h50, rd);
    check("R7 no write without cs", rd, 16'h5050);

    // R3: two back-to-back writes each land once, neighbour untouched
    int_write(8'h61, 16'h6161);
    bus_write(8'h60, 16'h0A0A);
    bus_write(8'h60, 16'h0B0B);
    int_read(8'h60, rd);
    check("R3 second write wins", rd, 16'h0B0B);
    int_read(8'h61, rd);
    check("R3 neighbour untouched", rd, 16'h6161);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule